// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake Sequencer

This block decides when a radio receiver is powered. When duty-cycled operation is enabled, it keeps the receiver asleep and wakes it on a fixed period. Each wake turns on the reference oscillator first. After a settling delay it turns on the frequency synthesizer and checks a signal-strength flag for a short sniff window. If no signal appears in that window, the receiver goes back to sleep. If a signal appears, the receiver stays on for a listen window so a packet can arrive. When duty-cycled operation is disabled, the receiver is simply held on.

All timing is counted in millisecond ticks supplied by the system. The durations are parameters: the wake period, the oscillator settle time, the sniff window and the listen window. The wake period is counted from the start of the previous wake, so wake instants do not move with the result of each cycle. The detection threshold level is captured when the block wakes and is presented to the analog front end for that whole wake. The block does not measure signal strength itself; it only consumes a detect flag.

Top module: `rx_wake_seq`

## Requirements
- R1: While `duty_en` is low, the state after the next clock edge is ON (code 4) with `osc_en` and `synth_en` both high, whatever the state before.
- R2: In SLEEP (code 0) `osc_en` and `synth_en` are both low. Raising `duty_en` while in ON moves the block to SLEEP at the next edge.
- R3: With `duty_en` high, the PERIOD_MS-th tick counted from enable, and every PERIOD_MS-th tick after that, starts a wake. A wake moves SLEEP to SETTLE (code 1). The period is counted from the previous wake and not from the return to sleep. A wake that falls while the block is not in SLEEP is dropped.
- R4: In SETTLE `osc_en` is high and `synth_en` is low. The SETTLE_MS-th tick in SETTLE moves the block to SNIFF (code 2), and `synth_en` rises at that point.
- R5: In SNIFF, if `sig_det` stays low, the SNIFF_MS-th tick returns the block to SLEEP.
- R6: In SNIFF, a high `sig_det` moves the block to LISTEN (code 3) at the next edge. `osc_en` and `synth_en` stay high.
- R7: In LISTEN, the LISTEN_MS-th tick returns the block to SLEEP unless an early exit happened before.
- R8: In LISTEN, a `pkt_done` pulse after or together with a `pkt_good` pulse in the same listen window returns the block to SLEEP at the next edge.
- R9: In LISTEN, a `pkt_done` pulse without an earlier `pkt_good` in that window has no effect, and the block stays in LISTEN.
- R10: `thr_sel` takes the value of `thr_sel_in` at the SLEEP-to-SETTLE edge and holds it until the next wake. In ON it follows `thr_sel_in` with one cycle of delay. It is 0 after reset.
- R11: `sig_det` has no effect outside SNIFF; for example, the block stays in SETTLE with `synth_en` low.
- R12: A synchronous reset (low `rst_n`) puts the block in SLEEP with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_en | input | 1 | High selects duty-cycled operation; low holds the receiver on |
| thr_sel_in | input | 1 | Requested detection threshold level |
| sig_det | input | 1 | Signal strength is above the threshold |
| pkt_good | input | 1 | Strobe: the received packet checked valid |
| pkt_done | input | 1 | Strobe: packet reception has finished |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| osc_en | output | 1 | Reference oscillator enable |
| synth_en | output | 1 | Synthesizer enable |
| thr_sel | output | 1 | Threshold level applied during the wake |
| state_o | output | 3 | Sequencer state: 0 SLEEP, 1 SETTLE, 2 SNIFF, 3 LISTEN, 4 ON |

## Verification
The state is visible directly on `state_o`, so a wrong transition shows up at the very next edge. A bad phase count shows up as `synth_en` rising or falling one tick early or late. A fault in the period counter moves the wake by whole ticks. It shows on the first wake after enable and again on the next wake, because the period is counted from the previous wake. A listen-window flag that is not cleared would allow a bare `pkt_done` to end a later listen early, and that is visible on the next cycle.

// File: rtl/rxw_pkg.sv
// Shared types for the receiver wake sequencer.
// Assumes: state codes are visible at the top port and must stay stable.
package rxw_pkg;
    typedef enum logic [2:0] {
        ST_SLEEP  = 3'd0,
        ST_SETTLE = 3'd1,
        ST_SNIFF  = 3'd2,
        ST_LISTEN = 3'd3,
        ST_ON     = 3'd4
    } rxw_state_e;
endpackage

// File: rtl/rxw_period_timer.sv
// Free-running wake period counter.
// Counts ms ticks while run is high and wraps every PERIOD_MS ticks.
// wake pulses on the tick that completes a period.
// Assumes: PERIOD_MS >= 2; the counter clears whenever run is low.
module rxw_period_timer #(
    parameter int PERIOD_MS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ms_tick,
    output logic wake
);
    localparam int CW = $clog2(PERIOD_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD_MS - 1);

    logic [CW-1:0] cnt_q;

    // Decode the completing tick of a period.
    assign wake = run && ms_tick && (cnt_q == LAST);

    // Advance the period count on each tick and wrap after a full period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (ms_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rxw_phase_timer.sv
// Times the settle, sniff and listen phases in ms ticks.
// restart clears the count on the edge where a new phase begins.
// expired pulses on the tick that ends the current phase.
// Assumes: every phase length is at least 1 tick.
module rxw_phase_timer
    import rxw_pkg::*;
#(
    parameter int SETTLE_MS = 2,
    parameter int SNIFF_MS  = 6,
    parameter int LISTEN_MS = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  rxw_state_e state,
    input  logic       ms_tick,
    output logic       expired
);
    localparam int MAXL = (LISTEN_MS > SNIFF_MS)
                          ? ((LISTEN_MS > SETTLE_MS) ? LISTEN_MS : SETTLE_MS)
                          : ((SNIFF_MS > SETTLE_MS) ? SNIFF_MS : SETTLE_MS);
    localparam int CW = $clog2(MAXL + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          timed;

    // Pick the final count of the current phase.
    always_comb begin
        timed = 1'b1;
        case (state)
            ST_SETTLE: last = CW'(SETTLE_MS - 1);
            ST_SNIFF:  last = CW'(SNIFF_MS - 1);
            ST_LISTEN: last = CW'(LISTEN_MS - 1);
            default: begin
                last  = '0;
                timed = 1'b0;
            end
        endcase
    end

    assign expired = timed && ms_tick && (cnt_q == last);

    // Count ticks within the phase and clear at each phase start.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (ms_tick && timed) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rxw_fsm.sv
// Wake sequencer state machine: SLEEP, SETTLE, SNIFF, LISTEN, plus ON.
// The block enters ON while duty-cycled operation is disabled.
// Holds the packet-good flag for the listen window and the latched threshold.
// Assumes: wake and expired are single-cycle pulses from the timers.
module rxw_fsm
    import rxw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       duty_en,
    input  logic       thr_sel_in,
    input  logic       sig_det,
    input  logic       pkt_good,
    input  logic       pkt_done,
    input  logic       wake,
    input  logic       expired,
    output rxw_state_e state,
    output logic       restart,
    output logic       thr_q
);
    rxw_state_e state_q, state_d;
    logic       good_q;

    assign state   = state_q;
    assign restart = (state_d != state_q);

    // Next-state decision; disable has priority over everything else.
    always_comb begin
        state_d = state_q;
        if (!duty_en) begin
            state_d = ST_ON;
        end else begin
            case (state_q)
                ST_ON:     state_d = ST_SLEEP;
                ST_SLEEP:  if (wake) state_d = ST_SETTLE;
                ST_SETTLE: if (expired) state_d = ST_SNIFF;
                ST_SNIFF: begin
                    if (sig_det)      state_d = ST_LISTEN;
                    else if (expired) state_d = ST_SLEEP;
                end
                ST_LISTEN: begin
                    if (pkt_done && (good_q || pkt_good)) state_d = ST_SLEEP;
                    else if (expired)                     state_d = ST_SLEEP;
                end
                default:   state_d = ST_SLEEP;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    // Remember a good packet seen within the current listen window.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_LISTEN) good_q <= 1'b0;
        else if (pkt_good)                  good_q <= 1'b1;
    end

    // Latch the threshold at wake; track it directly in ON.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= 1'b0;
        end else if (state_d == ST_ON
                     || (state_q == ST_SLEEP && state_d == ST_SETTLE)) begin
            thr_q <= thr_sel_in;
        end
    end
endmodule

// File: rtl/rx_wake_seq.sv
// Top of the duty-cycled receiver wake sequencer.
// Ties together the period timer, the phase timer and the state machine,
// and decodes the power enables from the state.
// Assumes: ms_tick is one clk wide; PERIOD_MS exceeds the sum of the phases.
module rx_wake_seq
    import rxw_pkg::*;
#(
    parameter int PERIOD_MS = 300,
    parameter int SETTLE_MS = 2,
    parameter int SNIFF_MS  = 6,
    parameter int LISTEN_MS = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       duty_en,
    input  logic       thr_sel_in,
    input  logic       sig_det,
    input  logic       pkt_good,
    input  logic       pkt_done,
    input  logic       ms_tick,
    output logic       osc_en,
    output logic       synth_en,
    output logic       thr_sel,
    output logic [2:0] state_o
);
    rxw_state_e st;
    logic       wake, expired, restart;

    rxw_period_timer #(.PERIOD_MS(PERIOD_MS)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (duty_en),
        .ms_tick (ms_tick),
        .wake    (wake)
    );

    rxw_phase_timer #(
        .SETTLE_MS (SETTLE_MS),
        .SNIFF_MS  (SNIFF_MS),
        .LISTEN_MS (LISTEN_MS)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .state   (st),
        .ms_tick (ms_tick),
        .expired (expired)
    );

    rxw_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .duty_en    (duty_en),
        .thr_sel_in (thr_sel_in),
        .sig_det    (sig_det),
        .pkt_good   (pkt_good),
        .pkt_done   (pkt_done),
        .wake       (wake),
        .expired    (expired),
        .state      (st),
        .restart    (restart),
        .thr_q      (thr_sel)
    );

    // Power enables decoded from the state.
    assign osc_en   = (st != ST_SLEEP);
    assign synth_en = (st == ST_SNIFF) || (st == ST_LISTEN) || (st == ST_ON);
    assign state_o  = st;
endmodule

// File: rtl/rxw_wake_checker.sv
// Assertion checker for rx_wake_seq, attached with bind.
// Observes ports only and counts sniff ticks itself.
module rxw_wake_checker #(
    parameter int SNIFF_MS = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       duty_en,
    input logic       sig_det,
    input logic       pkt_good,
    input logic       pkt_done,
    input logic       ms_tick,
    input logic       osc_en,
    input logic       synth_en,
    input logic [2:0] state_o
);
    int sniff_ticks;

    // Count ticks spent in the current sniff window.
    always_ff @(posedge clk) begin
        if (!rst_n || state_o != 3'd2) sniff_ticks <= 0;
        else if (ms_tick)              sniff_ticks <= sniff_ticks + 1;
    end

    assert_disable_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_en |=> (state_o == 3'd4 && osc_en && synth_en));

    assert_synth_needs_osc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !synth_en);

    assert_sleep_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && duty_en) |=> (state_o == 3'd0 || state_o == 3'd1));

    assert_settle_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && duty_en) |=> (state_o == 3'd1 || state_o == 3'd2));

    assert_sniff_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2) |-> (sniff_ticks < SNIFF_MS));

    assert_detect_listen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && duty_en && sig_det) |=> (state_o == 3'd3));

    assert_good_done_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && duty_en && pkt_good && pkt_done) |=> (state_o == 3'd0));
endmodule

bind rx_wake_seq rxw_wake_checker #(.SNIFF_MS(SNIFF_MS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .duty_en  (duty_en),
    .sig_det  (sig_det),
    .pkt_good (pkt_good),
    .pkt_done (pkt_done),
    .ms_tick  (ms_tick),
    .osc_en   (osc_en),
    .synth_en (synth_en),
    .state_o  (state_o)
);

// File: tb/rx_wake_seq_tb.sv
// Bench for rx_wake_seq: a vector table walk, then directed corner tests.
// Short durations are used: period 8, settle 2, sniff 3, listen 4 ticks.
module rx_wake_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic duty_en = 1'b0, thr_sel_in = 1'b0, sig_det = 1'b0;
    logic pkt_good = 1'b0, pkt_done = 1'b0, ms_tick = 1'b0;
    logic osc_en, synth_en, thr_sel;
    logic [2:0] state_o;
    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    rx_wake_seq #(.PERIOD_MS(8), .SETTLE_MS(2), .SNIFF_MS(3), .LISTEN_MS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .duty_en(duty_en), .thr_sel_in(thr_sel_in),
        .sig_det(sig_det), .pkt_good(pkt_good), .pkt_done(pkt_done),
        .ms_tick(ms_tick), .osc_en(osc_en), .synth_en(synth_en),
        .thr_sel(thr_sel), .state_o(state_o)
    );

    // Vector bits: [9]en [8]thr_in [7]sig [6]good [5]done [4]tick [3:1]state [0]thr
    localparam logic [9:0] VEC [38] = '{
        10'b0_0_0_0_0_0_100_0,                        // 0  R1 ON
        10'b1_0_0_0_0_0_000_0,                        // 1  R2 to SLEEP
        10'b1_0_0_0_0_1_000_0, 10'b1_0_0_0_0_1_000_0, // 2-8 R3 ticks 1..7
        10'b1_0_0_0_0_1_000_0, 10'b1_0_0_0_0_1_000_0,
        10'b1_0_0_0_0_1_000_0, 10'b1_0_0_0_0_1_000_0,
        10'b1_0_0_0_0_1_000_0,
        10'b1_1_0_0_0_1_001_1,                        // 9  R3 wake, R10 latch 1
        10'b1_0_0_0_0_1_001_1,                        // 10 R4 settle
        10'b1_0_0_0_0_1_010_1,                        // 11 R4 to SNIFF
        10'b1_0_0_0_0_1_010_1, 10'b1_0_0_0_0_1_010_1, // 12-13 R5
        10'b1_0_0_0_0_1_000_1,                        // 14 R5 abort
        10'b1_0_0_0_0_1_000_1, 10'b1_0_0_0_0_1_000_1, // 15-16 R3
        10'b1_0_0_0_0_1_001_0,                        // 17 R3 wake from previous wake
        10'b1_1_0_0_0_1_001_0,                        // 18 R10 held
        10'b1_1_0_0_0_1_010_0,                        // 19 R4
        10'b1_1_1_0_0_0_011_0,                        // 20 R6
        10'b1_1_0_1_0_0_011_0,                        // 21 R8 good
        10'b1_1_0_0_1_0_000_0,                        // 22 R8 done
        10'b1_1_0_0_0_1_000_0, 10'b1_1_0_0_0_1_000_0, // 23-27 R3
        10'b1_1_0_0_0_1_000_0, 10'b1_1_0_0_0_1_000_0,
        10'b1_1_0_0_0_1_000_0,
        10'b1_1_0_0_0_1_001_1,                        // 28 R3 wake, R10
        10'b1_0_0_0_0_1_001_1,                        // 29 R4
        10'b1_0_0_0_0_1_010_1,                        // 30 R4
        10'b1_0_1_0_0_1_011_1,                        // 31 R6
        10'b1_0_0_0_0_1_011_1, 10'b1_0_0_0_0_1_011_1, // 32-33 R7
        10'b1_0_0_0_1_0_011_1,                        // 34 R9 bare done
        10'b1_0_0_0_0_1_011_1,                        // 35 R7
        10'b1_0_0_0_0_1_000_1,                        // 36 R7 window end
        10'b0_0_0_0_0_0_100_0                         // 37 R1
    };

    function automatic string vec_tag(int i);
        if (i == 0 || i == 37) return "R1";
        if (i == 1)            return "R2";
        if (i == 34)           return "R9";
        if (i == 20 || i == 31) return "R6";
        if (i == 21 || i == 22) return "R8";
        if (i >= 12 && i <= 14) return "R5";
        if (i >= 32 && i <= 36) return "R7";
        if (i == 10 || i == 11 || i == 19 || i == 29 || i == 30) return "R4";
        if (i == 18)           return "R10";
        return "R3";
    endfunction

    // Drive one cycle of inputs at a falling edge and wait for the next one.
    task automatic step(input logic en, thr, sig, good, done, tick);
        duty_en = en; thr_sel_in = thr; sig_det = sig;
        pkt_good = good; pkt_done = done; ms_tick = tick;
        @(negedge clk);
    endtask

    // Compare state, enables and threshold with the values the requirements give.
    task automatic check(input logic [2:0] st, input logic thr, input string tag);
        logic [5:0] act, exp;
        act = {state_o, osc_en, synth_en, thr_sel};
        exp = {st, (st != 3'd0), (st >= 3'd2), thr};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: state/osc/synth/thr actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) step(1, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0);
        check(3'd0, 1'b0, "R12 reset state");
        rst_n = 1'b1;
        for (int i = 0; i < 38; i++) begin
            logic [9:0] v;
            v = VEC[i];
            step(v[9], v[8], v[7], v[6], v[5], v[4]);
            check(v[3:1], v[0], vec_tag(i));
        end
        // Directed: sig_det ignored in SETTLE (R11)
        step(1, 0, 0, 0, 0, 0);
        check(3'd0, 1'b0, "R2 enable from ON");
        ticks(7);
        check(3'd0, 1'b0, "R3 no wake before period");
        step(1, 0, 0, 0, 0, 1);
        check(3'd1, 1'b0, "R3 wake");
        step(1, 0, 1, 0, 0, 1);
        check(3'd1, 1'b0, "R11 sig_det in SETTLE");
        step(1, 0, 0, 0, 0, 1);
        check(3'd2, 1'b0, "R4 settle done");
        // Disable mid-sniff, threshold follows in ON (R1, R10)
        step(0, 1, 0, 0, 0, 0);
        check(3'd4, 1'b1, "R1 disable in SNIFF");
        step(0, 0, 0, 0, 0, 0);
        check(3'd4, 1'b0, "R10 ON follows input");
        // Good and done together end the listen window (R8)
        step(1, 0, 0, 0, 0, 0);
        ticks(8);
        check(3'd1, 1'b0, "R3 wake after re-enable");
        ticks(2);
        step(1, 0, 1, 0, 0, 0);
        check(3'd3, 1'b0, "R6 detect");
        step(1, 0, 0, 1, 1, 0);
        check(3'd0, 1'b0, "R8 good with done");
        // Reset in SETTLE (R12)
        ticks(5);
        step(1, 1, 0, 0, 0, 1);
        check(3'd1, 1'b1, "R10 latch at wake");
        rst_n = 1'b0;
        step(1, 0, 0, 0, 0, 0);
        check(3'd0, 1'b0, "R12 reset mid wake");
        rst_n = 1'b1;
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule